// File: doc/BRIEF.md
# Self-Correcting Gray Counter

A free-running counter whose output is Gray coded. It has no reset. After power-up both the count and its one-bit direction flop may hold any value, so the counter may start counting down instead of up. A small detector compares the previous count with the current one. When it sees the count fall from the all-zero code to the code for the maximum value, it knows the counter is going the wrong way. In the next step the count returns to zero and counts upward from then on.

The same detector clears any later corruption. If an upset flips the direction flop, the counter runs down to the next underflow wrap and then turns itself around. If an upset corrupts the count, the counter simply keeps stepping from the new value. A test-only preload port loads an arbitrary count and direction, which lets a bench model power-up states and upsets. In normal use the preload port is tied low.

Top module: `gray_dir_counter`

## Requirements
- R1: Outside a preload, every clock moves `gray_o` to an adjacent Gray code, so exactly one bit changes per step. Gray code of n is n XOR (n >> 1).
- R2: While `dir_up_o` is 1, each step moves the count from binary value n to (n+1) modulo 2^W.
- R3: While `dir_up_o` is 0 and the count is not the maximum code (binary 2^W-1, Gray 1 followed by zeros), each step moves from n to n-1.
- R4: When the count steps down from Gray 0 to the maximum code, the next step sets `dir_up_o` to 1 and returns the count to Gray 0.
- R5: Once `dir_up_o` is 1 it stays 1 until the next preload.
- R6: From any preloaded count and direction, `dir_up_o` is 1 no later than 2^W+1 clocks after the load.
- R7: Counting up from the maximum code wraps to Gray 0 and leaves the direction up.
- R8: With `preload_i` high at a clock edge, `gray_o` takes `preload_cnt_i` and `dir_up_o` takes `preload_dir_i` (1 = up).
- R9: With the default width W=4, upward counting has a period of exactly 16 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| preload_i | input | 1 | Test-only load strobe; tie low in use |
| preload_cnt_i | input | W | Gray count loaded on preload |
| preload_dir_i | input | 1 | Direction loaded on preload, 1 = up |
| gray_o | output | W | Current Gray count |
| dir_up_o | output | 1 | Current direction, 1 = up |

## Verification
A wrong direction bit shows at the ports as descending Gray codes. It remains visible for up to 2^W+1 clocks, until the underflow wrap from zero to the maximum code turns it around. A corrupted count shows as a single non-adjacent jump, and the following steps are adjacent codes again. The preload port is swept over every count and both directions, so each possible power-up state is seen to settle within the stated bound.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
  typedef enum logic {DIR_DN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/gdc_g2b.sv
module gdc_g2b #(
  parameter int W = 4
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  assign bin_o[W-1] = gray_i[W-1];
  for (genvar i = W-2; i >= 0; i--) begin : g_chain
    assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
  end
endmodule

// File: rtl/gdc_step.sv
module gdc_step #(
  parameter int W = 4
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] up_o,
  output logic [W-1:0] dn_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] bin, bin_up, bin_dn;

  gdc_g2b #(.W(W)) u_g2b (.gray_i(gray_i), .bin_o(bin));

  assign bin_up = bin + ONE;
  assign bin_dn = bin - ONE;
  assign up_o   = bin_up ^ (bin_up >> 1);
  assign dn_o   = bin_dn ^ (bin_dn >> 1);
endmodule

// File: rtl/gdc_wrap_det.sv
module gdc_wrap_det #(
  parameter int W = 4
) (
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] cur_i,
  output logic         wrap_dn_o
);
  localparam logic [W-1:0] G_ZERO = '0;
  localparam logic [W-1:0] G_MAX  = {1'b1, {(W-1){1'b0}}};

  // underflow step: zero code followed by max code
  assign wrap_dn_o = (prev_i == G_ZERO) && (cur_i == G_MAX);
endmodule

// File: rtl/gray_dir_counter.sv
module gray_dir_counter
  import gdc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         preload_i,
  input  logic [W-1:0] preload_cnt_i,
  input  logic         preload_dir_i,
  output logic [W-1:0] gray_o,
  output logic         dir_up_o
);
  logic [W-1:0] cnt_q, prev_q, cnt_up, cnt_dn, cnt_nxt;
  dir_e         dir_q, dir_eff;
  logic         wrap_dn;

  gdc_step #(.W(W)) u_step (
    .gray_i(cnt_q),
    .up_o  (cnt_up),
    .dn_o  (cnt_dn)
  );

  gdc_wrap_det #(.W(W)) u_wrap (
    .prev_i   (prev_q),
    .cur_i    (cnt_q),
    .wrap_dn_o(wrap_dn)
  );

  // correction takes effect in the same step that detects the wrap
  assign dir_eff = (dir_q == DIR_UP || wrap_dn) ? DIR_UP : DIR_DN;
  assign cnt_nxt = (dir_eff == DIR_UP) ? cnt_up : cnt_dn;

  // no reset: state settles by clocking through a wrap
  always_ff @(posedge clk_i) begin
    if (preload_i) begin
      cnt_q  <= preload_cnt_i;
      prev_q <= preload_cnt_i;
      dir_q  <= preload_dir_i ? DIR_UP : DIR_DN;
    end else begin
      cnt_q  <= cnt_nxt;
      prev_q <= cnt_q;
      dir_q  <= dir_eff;
    end
  end

  assign gray_o   = cnt_q;
  assign dir_up_o = (dir_q == DIR_UP);
endmodule

// File: rtl/gray_dir_counter_chk.sv
module gray_dir_counter_chk #(
  parameter int W = 4
) (
  input logic         clk_i,
  input logic         preload_i,
  input logic [W-1:0] preload_cnt_i,
  input logic         preload_dir_i,
  input logic [W-1:0] gray_o,
  input logic         dir_up_o
);
  localparam logic [W-1:0] G_ZERO = '0;
  localparam logic [W-1:0] G_MAX  = {1'b1, {(W-1){1'b0}}};
  localparam int           LIM    = (1 << W) + 1;

  function automatic logic [W-1:0] to_bin(logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [W-1:0] to_gray(logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic         seen_q = 1'b0;
  logic         pl_q   = 1'b0;
  logic [W+1:0] age_q  = '0;
  logic         step_ok;

  always_ff @(posedge clk_i) begin
    seen_q <= seen_q | preload_i;
    pl_q   <= preload_i;
    if (preload_i)        age_q <= '0;
    else if (~&age_q)     age_q <= age_q + 1'b1;
  end

  assign step_ok = seen_q && !pl_q;

  AST_ONE_BIT_STEP: assert property (@(posedge clk_i) disable iff (!seen_q || preload_i)
    step_ok |-> $countones(gray_o ^ $past(gray_o)) == 1); // R1

  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!seen_q || preload_i)
    (step_ok && $past(dir_up_o)) |-> gray_o == to_gray(to_bin($past(gray_o)) + 1'b1)); // R2

  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!seen_q || preload_i)
    (step_ok && !$past(dir_up_o) && $past(gray_o) != G_MAX)
      |-> gray_o == to_gray(to_bin($past(gray_o)) - 1'b1)); // R3

  AST_WRAP_FIX: assert property (@(posedge clk_i) disable iff (!seen_q || preload_i)
    (step_ok && !dir_up_o && gray_o == G_MAX && $past(gray_o) == G_ZERO)
      |=> (dir_up_o && gray_o == G_ZERO)); // R4

  AST_DIR_STICKY: assert property (@(posedge clk_i) disable iff (!seen_q || preload_i)
    dir_up_o |=> dir_up_o); // R5

  AST_SETTLE_BOUND: assert property (@(posedge clk_i) disable iff (!seen_q || preload_i)
    (int'(age_q) >= LIM) |-> dir_up_o); // R6

  AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!seen_q || preload_i)
    (step_ok && $past(dir_up_o) && $past(gray_o) == G_MAX)
      |-> (gray_o == G_ZERO && dir_up_o)); // R7

  AST_PRELOAD: assert property (@(posedge clk_i) disable iff ($isunknown(preload_i))
    preload_i |=> (gray_o == $past(preload_cnt_i) && dir_up_o == $past(preload_dir_i))); // R8
endmodule

bind gray_dir_counter gray_dir_counter_chk #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .preload_i    (preload_i),
  .preload_cnt_i(preload_cnt_i),
  .preload_dir_i(preload_dir_i),
  .gray_o       (gray_o),
  .dir_up_o     (dir_up_o)
);

// File: tb/tb_gray_dir_counter.sv
module tb_gray_dir_counter;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk_i = 1'b0;
  logic         preload_i = 1'b1;
  logic [W-1:0] preload_cnt_i = '0;
  logic         preload_dir_i = 1'b1;
  logic [W-1:0] gray_o;
  logic         dir_up_o;

  int total = 0;
  int bad   = 0;

  always #5 clk_i = ~clk_i;

  gray_dir_counter #(.W(W)) dut (
    .clk_i        (clk_i),
    .preload_i    (preload_i),
    .preload_cnt_i(preload_cnt_i),
    .preload_dir_i(preload_dir_i),
    .gray_o       (gray_o),
    .dir_up_o     (dir_up_o)
  );

  function automatic logic [W-1:0] gc(int n);
    logic [W-1:0] v;
    v = W'(n);
    return v ^ (v >> 1);
  endfunction

  function automatic int bv(logic [W-1:0] g);
    int r = 0;
    logic acc = 1'b0;
    for (int i = W-1; i >= 0; i--) begin
      acc = acc ^ g[i];
      r = (r << 1) | int'(acc);
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic load(int n, bit d);
    @(negedge clk_i);
    preload_i = 1'b1;
    preload_cnt_i = gc(n);
    preload_dir_i = d;
    @(negedge clk_i);
    preload_i = 1'b0;
  endtask

  task automatic t_preload;
    load(5, 1'b1);
    check(gray_o == gc(5), "R8 cnt", int'(gray_o), int'(gc(5)));
    check(dir_up_o == 1'b1, "R8 dir", int'(dir_up_o), 1);
    load(11, 1'b0);
    check(gray_o == gc(11), "R8 cnt", int'(gray_o), int'(gc(11)));
    check(dir_up_o == 1'b0, "R8 dir", int'(dir_up_o), 0);
  endtask

  task automatic t_up_walk;
    logic [W-1:0] p;
    load(N-3, 1'b1);
    for (int k = 0; k < N + 4; k++) begin
      p = gray_o;
      @(negedge clk_i);
      check(gray_o == gc((bv(p) + 1) % N), "R2 up step", int'(gray_o), int'(gc((bv(p) + 1) % N)));
      check($countones(gray_o ^ p) == 1, "R1 one bit", $countones(gray_o ^ p), 1);
      if (bv(p) == N-1) begin
        check(gray_o == '0, "R7 up wrap cnt", int'(gray_o), 0);
        check(dir_up_o == 1'b1, "R7 up wrap dir", int'(dir_up_o), 1);
      end
    end
  endtask

  task automatic t_down_walk;
    logic [W-1:0] p;
    load(9, 1'b0);
    for (int k = 0; k < 5; k++) begin
      p = gray_o;
      @(negedge clk_i);
      check(gray_o == gc(bv(p) - 1), "R3 down step", int'(gray_o), int'(gc(bv(p) - 1)));
      check($countones(gray_o ^ p) == 1, "R1 one bit", $countones(gray_o ^ p), 1);
      check(dir_up_o == 1'b0, "R3 dir", int'(dir_up_o), 0);
    end
  endtask

  task automatic t_wrap_fix;
    load(2, 1'b0);
    @(negedge clk_i);
    check(gray_o == gc(1), "R4 seq", int'(gray_o), int'(gc(1)));
    @(negedge clk_i);
    check(gray_o == gc(0), "R4 seq", int'(gray_o), 0);
    @(negedge clk_i);
    check(gray_o == gc(N-1), "R4 wrap", int'(gray_o), int'(gc(N-1)));
    check(dir_up_o == 1'b0, "R4 dir before fix", int'(dir_up_o), 0);
    @(negedge clk_i);
    check(gray_o == gc(0), "R4 back to zero", int'(gray_o), 0);
    check(dir_up_o == 1'b1, "R4 dir fixed", int'(dir_up_o), 1);
    @(negedge clk_i);
    check(gray_o == gc(1), "R4 counting up", int'(gray_o), int'(gc(1)));
  endtask

  task automatic t_settle;
    logic [W-1:0] p;
    for (int n = 0; n < N; n++) begin
      for (int d = 0; d < 2; d++) begin
        load(n, d[0]);
        repeat (N + 1) @(negedge clk_i);
        check(dir_up_o == 1'b1, "R6 settled", int'(dir_up_o), 1);
        for (int k = 0; k < 3; k++) begin
          p = gray_o;
          @(negedge clk_i);
          check(dir_up_o == 1'b1, "R5 stays up", int'(dir_up_o), 1);
          check(gray_o == gc((bv(p) + 1) % N), "R6 up after settle", int'(gray_o), int'(gc((bv(p) + 1) % N)));
        end
      end
    end
  endtask

  task automatic t_upset;
    int cur;
    load(7, 1'b1);
    repeat (4) @(negedge clk_i);
    cur = bv(gray_o);
    load(cur, 1'b0);
    check(dir_up_o == 1'b0, "R6 upset applied", int'(dir_up_o), 0);
    repeat (N + 1) @(negedge clk_i);
    check(dir_up_o == 1'b1, "R6 recovered", int'(dir_up_o), 1);
    load(cur + 3, 1'b1);
    @(negedge clk_i);
    check(gray_o == gc((cur + 4) % N), "R2 after count upset", int'(gray_o), int'(gc((cur + 4) % N)));
  endtask

  task automatic t_period;
    int steps = 0;
    load(0, 1'b1);
    do begin
      @(negedge clk_i);
      steps++;
    end while (gray_o != '0 && steps < 4 * N);
    check(steps == 16, "R9 period", steps, 16);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_preload();
    t_up_walk();
    t_down_walk();
    t_wrap_fix();
    t_settle();
    t_upset();
    t_period();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule